// File: doc/BRIEF.md
# Card Clock Divider with Session Source Detection

This block derives the clock sent to a smart card from a crystal-rate reference clock. It divides the reference by one of two even ratios. A level input chooses the ratio. A change of that input is first synchronized and then has to stay stable for a fixed number of reference cycles. After that it is applied only at the start of a high phase of the card clock, so no phase comes out shorter than half of the faster period.

The same block also decides, once per session, whether an external clock is driving the reference input. When the active-low activation command falls, a detection window opens. The window lasts a fixed number of pulses of a slow window strobe. Rising edges of an external-activity indication are counted while it is open. When it closes, the count selects between two outcomes: the internal oscillator enable is dropped and the source flag reports an external clock, or the enable is kept high and the flag reports the internal source. The crystal oscillator and the clock multiplexer themselves are outside this block; the multiplexer is represented only by the digital flag.

Top module: `card_clk_gen`

## Requirements
- R1: A synchronous reset sets card_clk low, osc_en high and ext_src low. After reset the card clock runs at the low-select ratio, which is DIV_LO = 4 reference cycles per period by default.
- R2: With ratio_sel settled high the card clock period is DIV_HI reference cycles (default 2). With ratio_sel settled low it is DIV_LO reference cycles (default 4). Both ratios are even parameters of at least 2.
- R3: In steady state each high phase and each low phase of card_clk lasts exactly half a period, which gives a 50% duty cycle.
- R4: ratio_sel passes through a two-flop synchronizer. A new value is accepted only after the synchronized value has stayed unchanged for SETTLE (10) reference cycles. A pulse shorter than that leaves the ratio unchanged.
- R5: An accepted ratio takes effect only at a low-to-high transition of card_clk. The low phase just before it keeps the old length. No phase is shorter than half of the smaller period or longer than half of the larger one.
- R6: Source detection starts on each falling edge of act_n, seen after a two-flop synchronizer. A new falling edge while a window is open restarts the window and discards the edges counted so far.
- R7: The window closes on the WIN_TICKS-th (16th) win_tick pulse after it opens. If at least MIN_EDGES (2) rising edges of ext_act were counted, including one that arrives in the closing cycle, ext_src goes to 1 and osc_en to 0. Otherwise ext_src goes to 0 and osc_en to 1.
- R8: osc_en and ext_src change only in the cycle after a win_tick pulse that closes a window. Activity on ext_act while no window is open has no effect.
- R9: osc_en and ext_src are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal-rate reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | Ratio select: 1 selects DIV_HI, 0 selects DIV_LO (asynchronous) |
| act_n | input | 1 | Active-low activation command (asynchronous) |
| win_tick | input | 1 | One-cycle strobe from the slow internal oscillator that sets the window length |
| ext_act | input | 1 | External clock activity indication (asynchronous) |
| card_clk | output | 1 | Divided card clock, registered |
| osc_en | output | 1 | Internal oscillator enable |
| ext_src | output | 1 | 1 when an external clock was detected for this session |

## Verification
The assertions check on every cycle that each card-clock phase stays between half the short and half the long period. They also check that every low phase matches the high phase before it, which means a ratio switch can only begin at a rising edge. They further check that the two source outputs stay complementary and move only right after a window strobe. Three behaviours need the bench's scenarios and its cycle-accurate reference model: the exact ten-cycle settling delay after synchronization, the rejection of short select pulses, and the effect of a restarted window on the edge count. The same holds for the edge-count threshold at one and two edges and for ignoring activity outside a window.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

  typedef enum logic {
    DET_IDLE = 1'b0,
    DET_OPEN = 1'b1
  } det_state_t;

  function automatic int half_of(input int div);
    return div / 2;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ccg_sync.sv
`timescale 1ns/1ps
module ccg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ccg_ratio_ctrl.sv
`timescale 1ns/1ps
module ccg_ratio_ctrl #(
  parameter int SETTLE = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_sync,
  output logic ratio_pend
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE);
  localparam logic [CW-1:0] LAST_C   = CW'(SETTLE - 1);

  logic          sel_prev;
  logic [CW-1:0] stable_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev   <= 1'b0;
      stable_cnt <= SETTLE_C;
      ratio_pend <= 1'b0;
    end else begin
      sel_prev <= sel_sync;
      if (sel_sync != sel_prev) begin
        stable_cnt <= '0;
      end else if (stable_cnt < SETTLE_C) begin
        stable_cnt <= stable_cnt + 1'b1;
        if (stable_cnt == LAST_C) ratio_pend <= sel_sync;
      end
    end
  end

endmodule

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider
  import ccg_pkg::*;
#(
  parameter int DIV_HI = 2,
  parameter int DIV_LO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ratio_pend,
  output logic clk_out
);

  localparam int HALF_HI  = half_of(DIV_HI);
  localparam int HALF_LO  = half_of(DIV_LO);
  localparam int HALF_MAX = max_of(HALF_HI, HALF_LO);
  localparam int HW       = $clog2(HALF_MAX + 1);
  localparam logic [HW-1:0] HALF_HI_C = HW'(HALF_HI);
  localparam logic [HW-1:0] HALF_LO_C = HW'(HALF_LO);

  logic [HW-1:0] half_cur;
  logic [HW-1:0] phase_cnt;
  logic          wrap;

  assign wrap = (phase_cnt == half_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cur  <= HALF_LO_C;
      phase_cnt <= '0;
      clk_out   <= 1'b0;
    end else if (wrap) begin
      phase_cnt <= '0;
      clk_out   <= ~clk_out;
      if (!clk_out) half_cur <= ratio_pend ? HALF_HI_C : HALF_LO_C;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ccg_src_detect.sv
`timescale 1ns/1ps
module ccg_src_detect
  import ccg_pkg::*;
#(
  parameter int WIN_TICKS = 16,
  parameter int MIN_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_sync,
  input  logic ext_sync,
  input  logic win_tick,
  output logic osc_en,
  output logic ext_src
);

  localparam int TW = $clog2(WIN_TICKS);
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(WIN_TICKS - 1);
  localparam logic [EW-1:0] EDGE_SAT  = EW'(MIN_EDGES);

  det_state_t    state;
  logic          act_prev;
  logic          ext_prev;
  logic [TW-1:0] tick_cnt;
  logic [EW-1:0] edge_cnt;
  logic [EW-1:0] edge_tot;
  logic          act_fall;
  logic          ext_rise;

  assign act_fall = act_prev & ~act_sync;
  assign ext_rise = ext_sync & ~ext_prev;

  always_comb begin
    if (ext_rise && edge_cnt != EDGE_SAT) edge_tot = edge_cnt + 1'b1;
    else                                  edge_tot = edge_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_prev <= 1'b1;
      ext_prev <= 1'b0;
    end else begin
      act_prev <= act_sync;
      ext_prev <= ext_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= DET_IDLE;
      tick_cnt <= '0;
      edge_cnt <= '0;
      osc_en   <= 1'b1;
      ext_src  <= 1'b0;
    end else if (act_fall) begin
      state    <= DET_OPEN;
      tick_cnt <= '0;
      edge_cnt <= '0;
    end else if (state == DET_OPEN) begin
      edge_cnt <= edge_tot;
      if (win_tick) begin
        if (tick_cnt == LAST_TICK) begin
          state   <= DET_IDLE;
          ext_src <= (edge_tot == EDGE_SAT);
          osc_en  <= (edge_tot != EDGE_SAT);
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen #(
  parameter int DIV_HI    = 2,
  parameter int DIV_LO    = 4,
  parameter int SETTLE    = 10,
  parameter int SYNC_LEN  = 2,
  parameter int WIN_TICKS = 16,
  parameter int MIN_EDGES = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic ratio_sel,
  input  logic act_n,
  input  logic win_tick,
  input  logic ext_act,
  output logic card_clk,
  output logic osc_en,
  output logic ext_src
);

  logic sel_sync;
  logic act_sync;
  logic ext_sync;
  logic ratio_pend;

  ccg_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sel_sync (
    .clk(ref_clk), .rst(rst), .d(ratio_sel), .q(sel_sync)
  );

  ccg_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_act_sync (
    .clk(ref_clk), .rst(rst), .d(act_n), .q(act_sync)
  );

  ccg_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_ext_sync (
    .clk(ref_clk), .rst(rst), .d(ext_act), .q(ext_sync)
  );

  ccg_ratio_ctrl #(.SETTLE(SETTLE)) u_ratio (
    .clk(ref_clk), .rst(rst), .sel_sync(sel_sync), .ratio_pend(ratio_pend)
  );

  ccg_divider #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_div (
    .clk(ref_clk), .rst(rst), .ratio_pend(ratio_pend), .clk_out(card_clk)
  );

  ccg_src_detect #(.WIN_TICKS(WIN_TICKS), .MIN_EDGES(MIN_EDGES)) u_det (
    .clk(ref_clk), .rst(rst), .act_sync(act_sync), .ext_sync(ext_sync),
    .win_tick(win_tick), .osc_en(osc_en), .ext_src(ext_src)
  );

endmodule

// File: rtl/ccg_checker.sv
`timescale 1ns/1ps
module ccg_checker #(
  parameter int DIV_HI = 2,
  parameter int DIV_LO = 4
) (
  input logic clk,
  input logic rst,
  input logic card_clk,
  input logic osc_en,
  input logic ext_src,
  input logic win_tick
);

  localparam int HALF_MIN = ((DIV_HI < DIV_LO) ? DIV_HI : DIV_LO) / 2;
  localparam int HALF_MAX = ((DIV_HI > DIV_LO) ? DIV_HI : DIV_LO) / 2;

  logic       prev_clk;
  logic [7:0] run_len;
  logic [7:0] hi_len;
  logic       has_hi;
  logic       toggled;

  assign toggled = (card_clk != prev_clk);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b0;
      run_len  <= '0;
      hi_len   <= '0;
      has_hi   <= 1'b0;
    end else begin
      prev_clk <= card_clk;
      if (toggled) begin
        run_len <= 8'd1;
        if (!card_clk) begin
          hi_len <= run_len;
          has_hi <= 1'b1;
        end
      end else if (run_len != 8'hFF) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (rst)
    toggled |-> (run_len >= 8'(HALF_MIN))); // R5

  AST_PHASE_MAX: assert property (@(posedge clk) disable iff (rst)
    toggled |-> (run_len <= 8'(HALF_MAX))); // R5

  AST_LOW_MATCHES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (toggled && card_clk && has_hi) |-> (run_len == hi_len)); // R3

  AST_RESULT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(osc_en) |-> $past(win_tick)); // R8

  AST_SRC_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    $countones({osc_en, ext_src}) == 1); // R9

endmodule

bind card_clk_gen ccg_checker #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_ccg_checker (
  .clk(ref_clk), .rst(rst), .card_clk(card_clk),
  .osc_en(osc_en), .ext_src(ext_src), .win_tick(win_tick)
);

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;

  localparam int DIV_HI = 2;
  localparam int DIV_LO = 4;
  localparam int SETTLE = 10;
  localparam int WIN    = 16;
  localparam int MINE   = 2;
  localparam int WT     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ratio_sel = 1'b0;
  logic act_n = 1'b1;
  logic win_tick = 1'b0;
  logic ext_act = 1'b0;
  logic card_clk, osc_en, ext_src;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int ext_period = 0;

  always #4 clk = ~clk;

  card_clk_gen i_card_clk_gen (
    .ref_clk(clk), .rst(rst), .ratio_sel(ratio_sel), .act_n(act_n),
    .win_tick(win_tick), .ext_act(ext_act),
    .card_clk(card_clk), .osc_en(osc_en), .ext_src(ext_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // stimulus generators, driven at the falling edge
  int tick_ctr = 0;
  int ext_ctr  = 0;
  always @(negedge clk) begin
    tick_ctr = (tick_ctr + 1) % WT;
    win_tick <= (tick_ctr == WT - 1);
    if (ext_period > 0) begin
      ext_ctr++;
      if (ext_ctr >= ext_period) begin
        ext_ctr = 0;
        ext_act <= ~ext_act;
      end
    end
  end

  // behavioural reference model
  int m_s1, m_s2, m_selq, m_cnt, m_pend, m_half, m_pc, m_out;
  int m_a1, m_a2, m_aq, m_e1, m_e2, m_eq;
  int m_win, m_ticks, m_edges, m_osc, m_ext;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_selq = 0; m_cnt = SETTLE; m_pend = 0;
      m_half = DIV_LO / 2; m_pc = 0; m_out = 0;
      m_a1 = 1; m_a2 = 1; m_aq = 1; m_e1 = 0; m_e2 = 0; m_eq = 0;
      m_win = 0; m_ticks = 0; m_edges = 0; m_osc = 1; m_ext = 0;
    end else begin
      int fall, rise, tot;
      if (m_pc == m_half - 1) begin
        m_pc = 0;
        if (m_out == 0) m_half = (m_pend != 0) ? DIV_HI / 2 : DIV_LO / 2;
        m_out = 1 - m_out;
      end else m_pc++;
      if (m_s2 != m_selq) m_cnt = 0;
      else if (m_cnt < SETTLE) begin
        if (m_cnt == SETTLE - 1) m_pend = m_s2;
        m_cnt++;
      end
      m_selq = m_s2; m_s2 = m_s1; m_s1 = int'(ratio_sel);
      fall = (m_aq == 1 && m_a2 == 0) ? 1 : 0;
      rise = (m_e2 == 1 && m_eq == 0) ? 1 : 0;
      if (fall != 0) begin
        m_win = 1; m_ticks = 0; m_edges = 0;
      end else if (m_win != 0) begin
        tot = m_edges + rise;
        if (tot > MINE) tot = MINE;
        m_edges = tot;
        if (win_tick) begin
          if (m_ticks == WIN - 1) begin
            m_win = 0;
            m_ext = (tot >= MINE) ? 1 : 0;
            m_osc = 1 - m_ext;
          end else m_ticks++;
        end
      end
      m_aq = m_a2; m_a2 = m_a1; m_a1 = int'(act_n);
      m_eq = m_e2; m_e2 = m_e1; m_e1 = int'(ext_act);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(card_clk) == m_out, "R5 card_clk vs model", int'(card_clk), m_out);
      chk(int'(osc_en) == m_osc, "R7 osc_en vs model", int'(osc_en), m_osc);
      chk(int'(ext_src) == m_ext, "R7 ext_src vs model", int'(ext_src), m_ext);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise;
    logic p;
    p = card_clk;
    forever begin
      @(negedge clk);
      if (card_clk && !p) break;
      p = card_clk;
    end
  endtask

  task automatic measure(output int period, output int high);
    period = 0; high = 0;
    wait_rise();
    forever begin
      if (card_clk) high++;
      period++;
      @(negedge clk);
      if (card_clk && period > 0 && high < period) break;
    end
  endtask

  int per, hi;

  initial begin
    wait_cyc(4);
    chk(card_clk == 1'b0, "R1 reset card_clk", int'(card_clk), 0);
    chk(osc_en == 1'b1, "R1 reset osc_en", int'(osc_en), 1);
    chk(ext_src == 1'b0, "R1 reset ext_src", int'(ext_src), 0);
    rst = 1'b0;
    wait_cyc(10);
    measure(per, hi);
    chk(per == DIV_LO, "R1 default period", per, DIV_LO);
    chk(hi == DIV_LO / 2, "R3 high phase at DIV_LO", hi, DIV_LO / 2);

    ratio_sel = 1'b1;
    wait_cyc(30);
    measure(per, hi);
    chk(per == DIV_HI, "R2 period with select high", per, DIV_HI);
    chk(hi == DIV_HI / 2, "R3 high phase at DIV_HI", hi, DIV_HI / 2);

    // R4: short pulse is rejected
    ratio_sel = 1'b0;
    wait_cyc(6);
    ratio_sel = 1'b1;
    wait_cyc(30);
    measure(per, hi);
    chk(per == DIV_HI, "R4 short select pulse ignored", per, DIV_HI);

    // R4: still old ratio within the settle delay
    ratio_sel = 1'b0;
    wait_cyc(2);
    measure(per, hi);
    chk(per == DIV_HI, "R4 ratio held during settle", per, DIV_HI);
    wait_cyc(30);
    measure(per, hi);
    chk(per == DIV_LO, "R2 period with select low", per, DIV_LO);

    // R7: external clock present
    ext_period = 3;
    act_n = 1'b0;
    wait_cyc(200);
    chk(ext_src == 1'b1, "R7 external clock detected", int'(ext_src), 1);
    chk(osc_en == 1'b0, "R7 oscillator disabled", int'(osc_en), 0);
    act_n = 1'b1;

    // R6: restart discards the edges already counted
    wait_cyc(5);
    act_n = 1'b0;
    wait_cyc(40);
    act_n = 1'b1;
    ext_period = 0;
    ext_act = 1'b0;
    wait_cyc(5);
    act_n = 1'b0;
    wait_cyc(10);
    chk(ext_src == 1'b1, "R8 outputs held while window open", int'(ext_src), 1);
    wait_cyc(200);
    chk(ext_src == 1'b0, "R6 restarted window sees no edges", int'(ext_src), 0);
    chk(osc_en == 1'b1, "R6 oscillator re-enabled", int'(osc_en), 1);
    act_n = 1'b1;

    // R8: activity with no window open
    ext_period = 3;
    wait_cyc(200);
    chk(ext_src == 1'b0, "R8 activity outside window ignored", int'(ext_src), 0);
    ext_period = 0;
    ext_act = 1'b0;

    // R7: exactly MINE edges counts as external
    wait_cyc(5);
    act_n = 1'b0;
    wait_cyc(20);
    ext_act = 1'b1; wait_cyc(4); ext_act = 1'b0;
    wait_cyc(10);
    ext_act = 1'b1; wait_cyc(4); ext_act = 1'b0;
    wait_cyc(200);
    chk(ext_src == 1'b1, "R7 two edges detected", int'(ext_src), 1);
    act_n = 1'b1;

    // R7: one edge is not enough
    wait_cyc(5);
    act_n = 1'b0;
    wait_cyc(20);
    ext_act = 1'b1; wait_cyc(4); ext_act = 1'b0;
    wait_cyc(200);
    chk(ext_src == 1'b0, "R7 single edge rejected", int'(ext_src), 0);
    chk(osc_en == 1'b1, "R9 osc_en complements ext_src", int'(osc_en), 1);
    act_n = 1'b1;
    wait_cyc(10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule